// File: doc/BRIEF.md
# Byte-Wide File-Register Execute Unit

This block is the execute stage of a small 8-bit processor with separate program and data memories. Each cycle it may accept one 14-bit instruction word from the decode stage. It splits the word into an operation code, a destination bit, and either a 7-bit file address or an 8-bit constant. It then reads the addressed byte from its internal 128-entry data store, passes the operands through an 8-bit ALU, and writes the result either into the working register W or back into the same file.

A file address register and a file data register record the most recent data-store access. The file data register holds the byte that was read, or the byte that was written. A jump instruction does not change any execute state. Instead, it raises a one-cycle request with a 10-bit target for the fetch stage. Results wrap modulo 256 and no flags are kept.

Top module: `fx_exec_unit`

## Requirements
- R1: The instruction word layout is: opcode in bits 13:8, destination bit in bit 7, file address in bits 6:0, and the constant in bits 7:0. For example, word 0220h is "subtract W from file 20h, result to W".
- R2: For opcodes that read a file and carry a destination bit, the bit selects where the result goes. Destination 0 writes W only and leaves the file untouched. Destination 1 writes the file only and leaves W unchanged.
- R3: Opcode 000111b computes W+file. Opcode 000110b computes W XOR file. Opcode 000010b computes file−W. All results are modulo 256.
- R4: Opcode 001000b (move file) passes the file byte unchanged to the destination.
- R5: Opcode 000001b (move W to file) writes W to the addressed file and leaves W unchanged.
- R6: Opcode 001010b computes file+1 modulo 256 (so FFh becomes 00h) to the destination. Opcode 000011b writes 00h to the addressed file and leaves W unchanged.
- R7: Opcode 111110b sets W to W plus bits 7:0 of the word, modulo 256.
- R8: Any word whose bits 13:10 are 1010b is a jump. In the next cycle `jump_req` is high for one cycle and `jump_target` equals bits 9:0. Jumps change neither W, the store, nor the access registers.
- R9: After an instruction that touches a file, `far_q` holds its address. `fdr_q` holds the byte read (destination 0) or the byte written (otherwise). `fwrite_q` is high exactly in the cycle after a file write.
- R10: A file write lands at the end of its cycle, so an instruction in the very next cycle that reads the same file sees the new byte.
- R11: Reset clears W, all 128 files, `far_q`, `fdr_q`, `fwrite_q` and `jump_req`.
- R12: Opcode 000000b, any other unassigned opcode, and any cycle with `instr_valid` low change no state: W, the store, `far_q` and `fdr_q` hold, and `fwrite_q` and `jump_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Execute `instr` this cycle |
| instr | input | 14 | Instruction word from the decode stage |
| w_q | output | 8 | Working register |
| far_q | output | 7 | File address of the last data-store access |
| fdr_q | output | 8 | Byte read or written by the last access |
| fwrite_q | output | 1 | The last executed instruction wrote a file |
| jump_req | output | 1 | Jump request to fetch, one cycle |
| jump_target | output | 10 | Jump destination |

## Verification
Every result of an instruction accepted at a rising edge appears at that same edge. This applies to W, the store, `far_q`, `fdr_q`, `fwrite_q` and the jump outputs. Each one is therefore due exactly one cycle after the word is presented.

The bench drives each word half a cycle before the edge and compares all outputs against its behavioural model at the following falling edge. Store contents are observed through later move-file reads into `fdr_q` and W. Back-to-back write-then-read pairs confirm that a write made at one edge is visible to the read that executes one cycle later.

// File: rtl/fx_pkg.sv
package fx_pkg;
   localparam int OPC_W = 6;
   localparam int JMP_W = 4;

   localparam logic [OPC_W-1:0] OPC_NOP   = 6'b000000;
   localparam logic [OPC_W-1:0] OPC_MOVWF = 6'b000001;
   localparam logic [OPC_W-1:0] OPC_SUBWF = 6'b000010;
   localparam logic [OPC_W-1:0] OPC_CLRF  = 6'b000011;
   localparam logic [OPC_W-1:0] OPC_XORWF = 6'b000110;
   localparam logic [OPC_W-1:0] OPC_ADDWF = 6'b000111;
   localparam logic [OPC_W-1:0] OPC_MOVF  = 6'b001000;
   localparam logic [OPC_W-1:0] OPC_INCF  = 6'b001010;
   localparam logic [OPC_W-1:0] OPC_ADDLW = 6'b111110;
   localparam logic [JMP_W-1:0] JMP_PREFIX = 4'b1010;

   typedef enum logic [3:0] {
      K_NOP, K_MOVWF, K_SUBWF, K_CLRF, K_XORWF,
      K_ADDWF, K_MOVF, K_INCF, K_ADDLW, K_GOTO
   } op_kind_e;

   typedef struct packed {
      op_kind_e kind;
      logic     rd_file;
      logic     wr_file;
      logic     wr_w;
   } ctl_t;
endpackage

// File: rtl/fx_decode.sv
module fx_decode
   import fx_pkg::*;
#(
   parameter int INSTR_W = 14,
   parameter int ADDR_W  = 7,
   parameter int DATA_W  = 8,
   parameter int PC_W    = 10
) (
   input  logic [INSTR_W-1:0] instr,
   output ctl_t               ctl,
   output logic [ADDR_W-1:0]  faddr,
   output logic [DATA_W-1:0]  lit,
   output logic [PC_W-1:0]    target
);
   logic [OPC_W-1:0] opc;
   logic             dbit;
   logic             is_jump;

   assign opc     = instr[INSTR_W-1 -: OPC_W];
   assign dbit    = instr[ADDR_W];
   assign faddr   = instr[ADDR_W-1:0];
   assign lit     = instr[DATA_W-1:0];
   assign target  = instr[PC_W-1:0];
   assign is_jump = (instr[INSTR_W-1 -: JMP_W] == JMP_PREFIX);

   always_comb begin
      ctl = '{kind: K_NOP, rd_file: 1'b0, wr_file: 1'b0, wr_w: 1'b0};
      if (is_jump) begin
         ctl.kind = K_GOTO;
      end else begin
         unique case (opc)
            OPC_MOVWF: begin ctl.kind = K_MOVWF; ctl.wr_file = 1'b1; end
            OPC_CLRF:  begin ctl.kind = K_CLRF;  ctl.wr_file = 1'b1; end
            OPC_ADDLW: begin ctl.kind = K_ADDLW; ctl.wr_w    = 1'b1; end
            OPC_SUBWF: ctl.kind = K_SUBWF;
            OPC_XORWF: ctl.kind = K_XORWF;
            OPC_ADDWF: ctl.kind = K_ADDWF;
            OPC_MOVF:  ctl.kind = K_MOVF;
            OPC_INCF:  ctl.kind = K_INCF;
            default:   ctl.kind = K_NOP;
         endcase
         if (ctl.kind inside {K_SUBWF, K_XORWF, K_ADDWF, K_MOVF, K_INCF}) begin
            ctl.rd_file = 1'b1;
            ctl.wr_file = dbit;
            ctl.wr_w    = ~dbit;
         end
      end
   end
endmodule

// File: rtl/fx_alu.sv
module fx_alu
   import fx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int SUB_STYLE = 0
) (
   input  op_kind_e          kind,
   input  logic [DATA_W-1:0] w,
   input  logic [DATA_W-1:0] f,
   input  logic [DATA_W-1:0] lit,
   output logic [DATA_W-1:0] y
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
   logic [DATA_W-1:0] diff;

   generate
      if (SUB_STYLE == 0) begin : g_sub_direct
         assign diff = f - w;
      end else begin : g_sub_complement
         assign diff = f + ~w + ONE;
      end
   endgenerate

   always_comb begin
      unique case (kind)
         K_MOVWF: y = w;
         K_SUBWF: y = diff;
         K_CLRF:  y = '0;
         K_XORWF: y = w ^ f;
         K_ADDWF: y = w + f;
         K_MOVF:  y = f;
         K_INCF:  y = f + ONE;
         K_ADDLW: y = w + lit;
         default: y = w;
      endcase
   end
endmodule

// File: rtl/fx_fstore.sv
module fx_fstore #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   logic [DATA_W-1:0] cells [DEPTH];

   assign rdata = cells[addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (we) begin
         cells[addr] <= wdata;
      end
   end
endmodule

// File: rtl/fx_exec_unit.sv
module fx_exec_unit
   import fx_pkg::*;
#(
   parameter int INSTR_W   = 14,
   parameter int ADDR_W    = 7,
   parameter int DATA_W    = 8,
   parameter int PC_W      = 10,
   parameter int SUB_STYLE = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_valid,
   input  logic [INSTR_W-1:0] instr,
   output logic [DATA_W-1:0]  w_q,
   output logic [ADDR_W-1:0]  far_q,
   output logic [DATA_W-1:0]  fdr_q,
   output logic               fwrite_q,
   output logic               jump_req,
   output logic [PC_W-1:0]    jump_target
);
   localparam int FIELD_W = OPC_W + 1 + ADDR_W;

   if (INSTR_W != FIELD_W) begin : g_bad_width
      $error("instruction width must equal opcode + destination + address");
   end
   if (DATA_W != ADDR_W + 1) begin : g_bad_lit
      $error("literal must span destination bit and address field");
   end
   if (PC_W > INSTR_W - JMP_W) begin : g_bad_pc
      $error("jump target overlaps the jump prefix");
   end

   ctl_t              ctl;
   logic [ADDR_W-1:0] faddr;
   logic [DATA_W-1:0] lit;
   logic [PC_W-1:0]   target;
   logic [DATA_W-1:0] rdata;
   logic [DATA_W-1:0] y;
   logic              do_wr;
   logic              do_acc;

   fx_decode #(
      .INSTR_W(INSTR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PC_W(PC_W)
   ) u_dec (
      .instr(instr), .ctl(ctl), .faddr(faddr), .lit(lit), .target(target)
   );

   fx_alu #(.DATA_W(DATA_W), .SUB_STYLE(SUB_STYLE)) u_alu (
      .kind(ctl.kind), .w(w_q), .f(rdata), .lit(lit), .y(y)
   );

   assign do_wr  = instr_valid & ctl.wr_file;
   assign do_acc = instr_valid & (ctl.rd_file | ctl.wr_file);

   fx_fstore #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .we(do_wr), .addr(faddr),
      .wdata(y), .rdata(rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_q         <= '0;
         far_q       <= '0;
         fdr_q       <= '0;
         fwrite_q    <= 1'b0;
         jump_req    <= 1'b0;
         jump_target <= '0;
      end else begin
         fwrite_q <= do_wr;
         jump_req <= instr_valid & (ctl.kind == K_GOTO);
         if (instr_valid && ctl.kind == K_GOTO) jump_target <= target;
         if (instr_valid && ctl.wr_w) w_q <= y;
         if (do_acc) begin
            far_q <= faddr;
            fdr_q <= ctl.wr_file ? y : rdata;
         end
      end
   end
endmodule

// File: rtl/fx_exec_chk.sv
module fx_exec_chk
   import fx_pkg::*;
#(
   parameter int INSTR_W = 14,
   parameter int ADDR_W  = 7,
   parameter int DATA_W  = 8,
   parameter int PC_W    = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               instr_valid,
   input logic [INSTR_W-1:0] instr,
   input logic [DATA_W-1:0]  w_q,
   input logic [ADDR_W-1:0]  far_q,
   input logic [DATA_W-1:0]  fdr_q,
   input logic               fwrite_q,
   input logic               jump_req,
   input logic [PC_W-1:0]    jump_target
);
   logic [OPC_W-1:0] opc;
   assign opc = instr[INSTR_W-1 -: OPC_W];

   p_jump_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      jump_req |-> ($past(instr_valid) &&
                    $past(instr[INSTR_W-1 -: JMP_W]) == JMP_PREFIX &&
                    jump_target == $past(instr[PC_W-1:0])));

   p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> ($stable(w_q) && $stable(far_q) && $stable(fdr_q) &&
                        !fwrite_q && !jump_req));

   p_addlw_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && opc == OPC_ADDLW) |=>
         (w_q == DATA_W'($past(w_q) + $past(instr[DATA_W-1:0]))));

   p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && opc == OPC_CLRF) |=>
         (fdr_q == '0 && fwrite_q && $stable(w_q) &&
          far_q == $past(instr[ADDR_W-1:0])));

   p_dest_w_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !instr[ADDR_W] &&
       (opc == OPC_ADDWF || opc == OPC_XORWF || opc == OPC_SUBWF ||
        opc == OPC_MOVF || opc == OPC_INCF)) |=> !fwrite_q);

   p_movwf_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && opc == OPC_MOVWF) |=>
         (fdr_q == $past(w_q) && fwrite_q && $stable(w_q)));
endmodule

bind fx_exec_unit fx_exec_chk #(
   .INSTR_W(INSTR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PC_W(PC_W)
) u_chk (.*);

// File: tb/fx_exec_unit_tb.sv
module fx_exec_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [13:0] instr = '0;
   logic [7:0]  w_q;
   logic [6:0]  far_q;
   logic [7:0]  fdr_q;
   logic        fwrite_q;
   logic        jump_req;
   logic [9:0]  jump_target;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [7:0] m_mem [128];
   logic [7:0] m_w, m_fdr;
   logic [6:0] m_far;
   logic       m_fw, m_jr;
   logic [9:0] m_jt;

   always #10 clk = ~clk;

   fx_exec_unit u_dut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
      .w_q(w_q), .far_q(far_q), .fdr_q(fdr_q), .fwrite_q(fwrite_q),
      .jump_req(jump_req), .jump_target(jump_target)
   );

   function automatic logic [13:0] fw(input logic [5:0] op, input bit d, input int a);
      return {op, d, 7'(a)};
   endfunction
   function automatic logic [13:0] lw(input logic [5:0] op, input int k);
      return {op, 8'(k)};
   endfunction

   task automatic compare(input string tag);
      checks++;
      if (w_q !== m_w || far_q !== m_far || fdr_q !== m_fdr || fwrite_q !== m_fw ||
          jump_req !== m_jr || jump_target !== m_jt) begin
         errors++;
         $display("FAIL %s actual w=%h far=%h fdr=%h fw=%b jr=%b jt=%h expected w=%h far=%h fdr=%h fw=%b jr=%b jt=%h",
                  tag, w_q, far_q, fdr_q, fwrite_q, jump_req, jump_target,
                  m_w, m_far, m_fdr, m_fw, m_jr, m_jt);
      end
   endtask

   // behavioural reference of one execute cycle
   task automatic step(input bit v, input logic [13:0] ins, input string tag);
      int op, d, a, k, f, r;
      op = int'(ins[13:8]); d = int'(ins[7]); a = int'(ins[6:0]); k = int'(ins[7:0]);
      f = int'(m_mem[a]);
      m_fw = 0; m_jr = 0;
      if (v) begin
         if (ins[13:10] == 4'b1010) begin
            m_jr = 1; m_jt = ins[9:0];
         end else if (op == 6'h01 || op == 6'h03) begin
            r = (op == 6'h01) ? int'(m_w) : 0;
            m_mem[a] = 8'(r); m_far = 7'(a); m_fdr = 8'(r); m_fw = 1;
         end else if (op == 6'h3E) begin
            m_w = 8'((int'(m_w) + k) % 256);
         end else if (op == 6'h02 || op == 6'h06 || op == 6'h07 ||
                      op == 6'h08 || op == 6'h0A) begin
            case (op)
               6'h02:   r = (f - int'(m_w) + 256) % 256;
               6'h06:   r = f ^ int'(m_w);
               6'h07:   r = (f + int'(m_w)) % 256;
               6'h08:   r = f;
               default: r = (f + 1) % 256;
            endcase
            m_far = 7'(a);
            if (d == 1) begin
               m_mem[a] = 8'(r); m_fdr = 8'(r); m_fw = 1;
            end else begin
               m_w = 8'(r); m_fdr = 8'(f);
            end
         end
      end
      instr_valid = v; instr = ins;
      @(negedge clk);
      compare(tag);
   endtask

   task automatic ex(input logic [13:0] ins, input string tag);
      step(1'b1, ins, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
      m_w = 0; m_fdr = 0; m_far = 0; m_fw = 0; m_jr = 0; m_jt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare("R11 reset state");
      step(1'b0, 14'h0, "R11 idle after reset");

      ex(lw(6'h3E, 8'h25), "R7 addlw");
      ex(fw(6'h01, 1, 5), "R5 movwf");
      ex(lw(6'h3E, 8'hF0), "R7 addlw wrap");
      ex(fw(6'h07, 0, 5), "R3 addwf to W");
      ex(fw(6'h07, 1, 5), "R2 addwf to file");
      ex(fw(6'h02, 0, 5), "R3 subwf");
      ex(fw(6'h02, 0, 6), "R3 subwf wrap");
      ex(fw(6'h06, 1, 5), "R3 xorwf to file");
      ex(fw(6'h08, 0, 5), "R4 movf to W");
      ex(fw(6'h08, 1, 5), "R4 movf to file");
      ex(14'h0220, "R1 word 0220h");
      ex(fw(6'h0A, 1, 7), "R6 incf file");
      ex(fw(6'h0A, 1, 7), "R6 incf file again");
      ex(lw(6'h3E, int'(8'hFF - m_w)), "R7 reach FFh");
      ex(fw(6'h01, 1, 9), "R5 movwf FFh");
      ex(fw(6'h0A, 0, 9), "R6 incf FFh to W");
      ex(fw(6'h0A, 1, 9), "R6 incf FFh to file");
      ex(fw(6'h08, 0, 9), "R10 read after incf");
      ex(fw(6'h03, 1, 5), "R6 clrf");
      ex(fw(6'h08, 0, 5), "R10 read after clrf");
      ex(fw(6'h01, 1, 10), "R9 write access regs");
      ex(fw(6'h08, 0, 10), "R10 back-to-back read");
      ex({4'b1010, 10'h3A5}, "R8 goto");
      ex({4'b1010, 10'h017}, "R8 goto back-to-back");
      step(1'b0, {4'b1010, 10'h2AA}, "R12 invalid goto");
      ex(fw(6'h00, 1, 5), "R12 nop");
      ex(fw(6'h33, 1, 5), "R12 unassigned opcode");
      step(1'b0, fw(6'h03, 1, 10), "R12 invalid clrf");
      ex(fw(6'h08, 0, 10), "R12 file kept");

      for (int n = 0; n < 400; n++) begin
         int a;
         a = int'($urandom % 16);
         case ($urandom % 10)
            0: ex(fw(6'h07, 1'($urandom), a), "R3 mix add");
            1: ex(fw(6'h06, 1'($urandom), a), "R3 mix xor");
            2: ex(fw(6'h02, 1'($urandom), a), "R3 mix sub");
            3: ex(fw(6'h08, 1'($urandom), a), "R4 mix move");
            4: ex(fw(6'h01, 1, a), "R5 mix movwf");
            5: ex(fw(6'h0A, 1'($urandom), a), "R6 mix incf");
            6: ex(fw(6'h03, 1, a), "R6 mix clrf");
            7: ex(lw(6'h3E, int'($urandom % 256)), "R7 mix addlw");
            8: ex({4'b1010, 10'($urandom)}, "R8 mix goto");
            default: step(1'($urandom), 14'($urandom), "R12 mix other");
         endcase
      end

      for (int a = 0; a < 128; a++) ex(fw(6'h08, 0, a), "R9 store sweep");

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule